// File: doc/BRIEF.md
# Single-Entry ARP Resolver

This block resolves IPv4 addresses to Ethernet MAC addresses for a node on a point-to-point link. The IPv4 transmitter asks for the MAC address of a target IP. The block answers at once from a one-entry cache when the address is already known. On a miss it builds an ARP request frame and queues it for a shared MAC transmit path. It then waits for an answer, retries a fixed number of times, and finally reports either the resolved address or an error.

The block also watches the MAC receive byte stream in parallel with the IPv4 receiver. It only listens and never applies backpressure. It checks each frame's ARP header and counts well-formed ARP frames. A frame whose sender IP is the pending lookup target fills the cache. A request asking for the local IP is answered with a reply frame. Transmission goes through a request/grant handshake with an external arbiter, which favours the IP path. After the grant the bytes are handed over on a valid/ready stream.

Three cooperating state machines do the work: a receive parser, a lookup controller that owns the cache and the retry timer, and a frame builder that owns the transmit stream.

Top module: `arp_resolver`

## Requirements
- R1: A lookup whose IP equals the cached entry raises `lk_done` for one cycle, in the cycle after `lk_req` is sampled. `lk_mac` then shows the cached MAC, and no frame is transmitted.
- R2: A lookup that misses transmits one 42-byte request frame, with these bytes in wire order:
  - destination FF:FF:FF:FF:FF:FF, then source `local_mac`;
  - EtherType 0x0806, hardware type 0x0001, protocol type 0x0800, sizes 6 and 4;
  - opcode 0x0001;
  - sender MAC `local_mac`, sender IP `local_ip`;
  - target MAC all zero, target IP the lookup IP.
  All fields are most significant byte first.
- R3: Transmit handshake:
  - `tx_req` is raised before any byte, and `tx_valid` only rises after `tx_grant` has been sampled high.
  - `tx_data` holds while `tx_valid` is high and `tx_ready` is low.
  - `tx_last` marks the 42nd byte, and `tx_req` stays high until that byte is taken.
- R4: While a lookup is pending, a received ARP frame whose sender IP (bytes 28..31) equals the target overwrites the cache with its sender MAC (bytes 22..27). `lk_done` follows with that MAC, and a later lookup of that IP hits.
- R5: With no matching answer, the request is resent every `timeout_cycles` cycles. After 1+RETRIES frames in total and one more timeout, `lk_err` pulses once and `lk_done` does not.
- R6: A received request (opcode 0x0001) whose target IP (bytes 38..41) equals `local_ip` produces a reply frame:
  - opcode 0x0002;
  - destination and target MAC set to the requester MAC;
  - target IP set to the requester IP.
  A request for any other IP, or a reply, produces no frame.
- R7: `arp_rx_count` counts received frames that meet all of these conditions, and wraps modulo 256:
  - bytes 12..20 equal 08 06 00 01 08 00 06 04 00;
  - byte 21 is 01 or 02;
  - the frame has at least 42 bytes.
  Frames shorter than 42 bytes, or with any of those bytes wrong, are not counted and not acted on.
- R8: A received frame whose sender IP differs from the pending target leaves the cache unchanged.
- R9: After reset, `lk_done`, `lk_err`, `tx_req`, `tx_valid` and `arp_rx_count` are zero, and the cache is empty, so the first lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| local_ip | input | 32 | This node's IPv4 address |
| local_mac | input | 48 | This node's MAC address |
| timeout_cycles | input | TMR_W | Cycles to wait for an answer before a retry |
| lk_req | input | 1 | One-cycle lookup request |
| lk_ip | input | 32 | IP address to resolve, valid with `lk_req` |
| lk_done | output | 1 | One-cycle pulse: lookup resolved |
| lk_err | output | 1 | One-cycle pulse: lookup failed after retries |
| lk_mac | output | 48 | Cached MAC address, valid with `lk_done` |
| rx_data | input | 8 | Received frame byte |
| rx_valid | input | 1 | `rx_data` holds a byte |
| rx_last | input | 1 | Last byte of the received frame |
| tx_req | output | 1 | Request for the shared transmit path |
| tx_grant | input | 1 | Arbiter grant |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | `tx_data` holds a byte |
| tx_last | output | 1 | Last byte of the transmitted frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| arp_rx_count | output | 8 | Count of well-formed ARP frames received |

## Verification
The bench corrupts each fixed header byte and the opcode byte one at a time, and sends a frame one byte too short. A parser that skipped any of those checks would count the frame or act on it. It stalls the transmit stream with a pseudo-random ready pattern and delays the grant. A builder that advanced on an unaccepted byte, or began before the grant, would emit a corrupt or early frame. It sends a non-matching answer during a lookup and lets the retries expire. A controller that cached any answer, or miscounted its retries, would report done, send the wrong number of frames, or return a stale MAC on the next hit. It also drives the counter through a full wrap, so an off-by-one or saturating counter shows.

// File: rtl/arp_pkg.sv
package arp_pkg;

    localparam int FRAME_BYTES = 42;
    localparam int FRAME_BITS  = FRAME_BYTES * 8;

    typedef enum logic [1:0] {TX_IDLE, TX_WAIT_GNT, TX_SEND} tx_state_e;
    typedef enum logic       {LK_IDLE, LK_PENDING}          lk_state_e;

    // Expected value of the fixed header bytes; bit 8 set when the byte is checked.
    function automatic logic [8:0] fixed_hdr_byte(input logic [5:0] pos);
        case (pos)
            6'd12:   return 9'h108;
            6'd13:   return 9'h106;
            6'd14:   return 9'h100;
            6'd15:   return 9'h101;
            6'd16:   return 9'h108;
            6'd17:   return 9'h100;
            6'd18:   return 9'h106;
            6'd19:   return 9'h104;
            6'd20:   return 9'h100;
            default: return 9'h000;
        endcase
    endfunction

endpackage

// File: rtl/arp_rx_parse.sv
module arp_rx_parse
    import arp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_last,
    output logic        pkt_ok,
    output logic        pkt_is_req,
    output logic [47:0] pkt_sha,
    output logic [31:0] pkt_spa,
    output logic [31:0] pkt_tpa,
    output logic [7:0]  pkt_count
);

    typedef struct packed {
        logic [5:0]  pos;
        logic        bad;
        logic [7:0]  op;
        logic [47:0] sha;
        logic [31:0] spa;
        logic [31:0] tpa;
        logic        ok;
        logic [7:0]  cnt;
    } rx_st_t;

    rx_st_t st_q, st_d;

    always_comb begin
        logic [8:0] fx;
        logic       bad_now;
        st_d    = st_q;
        st_d.ok = 1'b0;
        fx      = fixed_hdr_byte(st_q.pos);
        bad_now = st_q.bad;
        if (rx_valid) begin
            if (fx[8] && rx_data != fx[7:0]) bad_now = 1'b1;
            if (st_q.pos == 6'd21) begin
                st_d.op = rx_data;
                if (rx_data != 8'h01 && rx_data != 8'h02) bad_now = 1'b1;
            end
            if (st_q.pos >= 6'd22 && st_q.pos <= 6'd27) st_d.sha = {st_q.sha[39:0], rx_data};
            if (st_q.pos >= 6'd28 && st_q.pos <= 6'd31) st_d.spa = {st_q.spa[23:0], rx_data};
            if (st_q.pos >= 6'd38 && st_q.pos <= 6'd41) st_d.tpa = {st_q.tpa[23:0], rx_data};
            st_d.bad = bad_now;
            if (st_q.pos != 6'd63) st_d.pos = st_q.pos + 6'd1;
            if (rx_last) begin
                st_d.pos = '0;
                st_d.bad = 1'b0;
                if (!bad_now && st_q.pos >= 6'd41) begin
                    st_d.ok  = 1'b1;
                    st_d.cnt = st_q.cnt + 8'd1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_ok     = st_q.ok;
    assign pkt_is_req = (st_q.op == 8'h01);
    assign pkt_sha    = st_q.sha;
    assign pkt_spa    = st_q.spa;
    assign pkt_tpa    = st_q.tpa;
    assign pkt_count  = st_q.cnt;

endmodule

// File: rtl/arp_lookup.sv
module arp_lookup
    import arp_pkg::*;
#(
    parameter int RETRIES = 2,
    parameter int TMR_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [31:0]      lk_ip,
    input  logic [TMR_W-1:0] timeout_cycles,
    input  logic             pkt_ok,
    input  logic [47:0]      pkt_sha,
    input  logic [31:0]      pkt_spa,
    output logic             lk_done,
    output logic             lk_err,
    output logic [47:0]      lk_mac,
    output logic             send_req,
    output logic [31:0]      target_ip
);

    localparam int TRY_W = $clog2(RETRIES + 1) + 1;

    typedef struct packed {
        lk_state_e        state;
        logic [31:0]      pend_ip;
        logic             c_vld;
        logic [31:0]      c_ip;
        logic [47:0]      c_mac;
        logic [TMR_W-1:0] timer;
        logic [TRY_W-1:0] tries;
        logic             done;
        logic             err;
        logic             send;
    } lk_st_t;

    lk_st_t st_q, st_d;

    always_comb begin
        logic [TMR_W:0] t_next;
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        st_d.send = 1'b0;
        t_next    = {1'b0, st_q.timer} + 1'b1;
        case (st_q.state)
            LK_IDLE: begin
                if (lk_req) begin
                    if (st_q.c_vld && st_q.c_ip == lk_ip) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.pend_ip = lk_ip;
                        st_d.state   = LK_PENDING;
                        st_d.timer   = '0;
                        st_d.tries   = '0;
                        st_d.send    = 1'b1;
                    end
                end
            end
            default: begin
                if (pkt_ok && pkt_spa == st_q.pend_ip) begin
                    st_d.c_vld = 1'b1;
                    st_d.c_ip  = st_q.pend_ip;
                    st_d.c_mac = pkt_sha;
                    st_d.done  = 1'b1;
                    st_d.state = LK_IDLE;
                end else if (t_next >= {1'b0, timeout_cycles}) begin
                    st_d.timer = '0;
                    if (st_q.tries == TRY_W'(RETRIES)) begin
                        st_d.err   = 1'b1;
                        st_d.state = LK_IDLE;
                    end else begin
                        st_d.tries = st_q.tries + 1'b1;
                        st_d.send  = 1'b1;
                    end
                end else begin
                    st_d.timer = t_next[TMR_W-1:0];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_done   = st_q.done;
    assign lk_err    = st_q.err;
    assign lk_mac    = st_q.c_mac;
    assign send_req  = st_q.send;
    assign target_ip = st_q.pend_ip;

endmodule

// File: rtl/arp_tx_build.sv
module arp_tx_build
    import arp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] local_ip,
    input  logic [47:0] local_mac,
    input  logic        send_req,
    input  logic [31:0] target_ip,
    input  logic        pkt_ok,
    input  logic        pkt_is_req,
    input  logic [47:0] pkt_sha,
    input  logic [31:0] pkt_spa,
    input  logic [31:0] pkt_tpa,
    output logic        tx_req,
    input  logic        tx_grant,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready
);

    typedef struct packed {
        tx_state_e   state;
        logic [5:0]  pos;
        logic        req_pend;
        logic [31:0] req_ip;
        logic        rep_pend;
        logic [47:0] rep_mac;
        logic [31:0] rep_ip;
        logic        cur_rep;
        logic [47:0] cur_mac;
        logic [31:0] cur_ip;
    } tx_st_t;

    tx_st_t st_q, st_d;
    logic [FRAME_BITS-1:0] frame, shifted;

    always_comb begin
        st_d = st_q;
        case (st_q.state)
            TX_IDLE: begin
                if (st_q.rep_pend) begin
                    st_d.rep_pend = 1'b0;
                    st_d.cur_rep  = 1'b1;
                    st_d.cur_mac  = st_q.rep_mac;
                    st_d.cur_ip   = st_q.rep_ip;
                    st_d.state    = TX_WAIT_GNT;
                end else if (st_q.req_pend) begin
                    st_d.req_pend = 1'b0;
                    st_d.cur_rep  = 1'b0;
                    st_d.cur_mac  = '0;
                    st_d.cur_ip   = st_q.req_ip;
                    st_d.state    = TX_WAIT_GNT;
                end
            end
            TX_WAIT_GNT: begin
                if (tx_grant) begin
                    st_d.state = TX_SEND;
                    st_d.pos   = '0;
                end
            end
            default: begin
                if (tx_ready) begin
                    if (st_q.pos == 6'(FRAME_BYTES - 1)) st_d.state = TX_IDLE;
                    else                                 st_d.pos   = st_q.pos + 6'd1;
                end
            end
        endcase
        if (send_req) begin
            st_d.req_pend = 1'b1;
            st_d.req_ip   = target_ip;
        end
        if (pkt_ok && pkt_is_req && pkt_tpa == local_ip) begin
            st_d.rep_pend = 1'b1;
            st_d.rep_mac  = pkt_sha;
            st_d.rep_ip   = pkt_spa;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        frame = {st_q.cur_rep ? st_q.cur_mac : 48'hFFFF_FFFF_FFFF,
                 local_mac, 16'h0806, 16'h0001, 16'h0800, 8'h06, 8'h04,
                 st_q.cur_rep ? 16'h0002 : 16'h0001,
                 local_mac, local_ip, st_q.cur_mac, st_q.cur_ip};
        shifted = frame << {st_q.pos, 3'b000};
    end

    assign tx_data  = shifted[FRAME_BITS-1 -: 8];
    assign tx_req   = (st_q.state != TX_IDLE);
    assign tx_valid = (st_q.state == TX_SEND);
    assign tx_last  = (st_q.state == TX_SEND) && (st_q.pos == 6'(FRAME_BYTES - 1));

endmodule

// File: rtl/arp_resolver.sv
module arp_resolver #(
    parameter int RETRIES = 2,
    parameter int TMR_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      local_ip,
    input  logic [47:0]      local_mac,
    input  logic [TMR_W-1:0] timeout_cycles,
    input  logic             lk_req,
    input  logic [31:0]      lk_ip,
    output logic             lk_done,
    output logic             lk_err,
    output logic [47:0]      lk_mac,
    input  logic [7:0]       rx_data,
    input  logic             rx_valid,
    input  logic             rx_last,
    output logic             tx_req,
    input  logic             tx_grant,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    output logic             tx_last,
    input  logic             tx_ready,
    output logic [7:0]       arp_rx_count
);

    logic        pkt_ok, pkt_is_req;
    logic [47:0] pkt_sha;
    logic [31:0] pkt_spa, pkt_tpa;
    logic        send_req;
    logic [31:0] target_ip;

    arp_rx_parse u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_last    (rx_last),
        .pkt_ok     (pkt_ok),
        .pkt_is_req (pkt_is_req),
        .pkt_sha    (pkt_sha),
        .pkt_spa    (pkt_spa),
        .pkt_tpa    (pkt_tpa),
        .pkt_count  (arp_rx_count)
    );

    arp_lookup #(.RETRIES(RETRIES), .TMR_W(TMR_W)) u_lookup (
        .clk            (clk),
        .rst_n          (rst_n),
        .lk_req         (lk_req),
        .lk_ip          (lk_ip),
        .timeout_cycles (timeout_cycles),
        .pkt_ok         (pkt_ok),
        .pkt_sha        (pkt_sha),
        .pkt_spa        (pkt_spa),
        .lk_done        (lk_done),
        .lk_err         (lk_err),
        .lk_mac         (lk_mac),
        .send_req       (send_req),
        .target_ip      (target_ip)
    );

    arp_tx_build u_build (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_ip   (local_ip),
        .local_mac  (local_mac),
        .send_req   (send_req),
        .target_ip  (target_ip),
        .pkt_ok     (pkt_ok),
        .pkt_is_req (pkt_is_req),
        .pkt_sha    (pkt_sha),
        .pkt_spa    (pkt_spa),
        .pkt_tpa    (pkt_tpa),
        .tx_req     (tx_req),
        .tx_grant   (tx_grant),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready)
    );

endmodule

// File: rtl/arp_resolver_chk.sv
module arp_resolver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lk_done,
    input logic       lk_err,
    input logic       tx_req,
    input logic       tx_grant,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_last,
    input logic       tx_ready,
    input logic [7:0] arp_rx_count
);

    // R1 / R5: a lookup ends either resolved or failed, never both
    p_done_xor_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_done && lk_err));

    // R3: a byte is only offered while the path is requested
    p_valid_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_req);

    // R3: a stalled byte is held
    p_hold_on_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R3: streaming starts only after a grant
    p_start_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(tx_grant));

    // R3: the end marker only accompanies a byte
    p_last_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R7: the receive counter steps by at most one per cycle
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (arp_rx_count == $past(arp_rx_count) ||
                  arp_rx_count == $past(arp_rx_count) + 8'd1));

endmodule

bind arp_resolver arp_resolver_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_done      (lk_done),
    .lk_err       (lk_err),
    .tx_req       (tx_req),
    .tx_grant     (tx_grant),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .tx_last      (tx_last),
    .tx_ready     (tx_ready),
    .arp_rx_count (arp_rx_count)
);

// File: tb/arp_resolver_bench.sv
module arp_resolver_bench;

    localparam int RETRIES = 2;
    localparam int TMR_W   = 16;
    localparam logic [31:0] MY_IP  = 32'hC0A8_0A01;
    localparam logic [47:0] MY_MAC = 48'h0200_1122_3344;
    localparam logic [31:0] IP_A = 32'hC0A8_0A07, IP_B = 32'hC0A8_0A09;
    localparam logic [31:0] IP_C = 32'hC0A8_0A0C, IP_X = 32'hC0A8_0A21;
    localparam logic [47:0] MAC_A = 48'h0A0B_0C0D_0E0F, MAC_C = 48'h1111_2222_3333;
    localparam logic [47:0] MAC_X = 48'h5A5A_A5A5_0102;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [TMR_W-1:0] timeout_cycles = 16'd300;
    logic lk_req = 1'b0;
    logic [31:0] lk_ip = '0;
    logic lk_done, lk_err, tx_req, tx_valid, tx_last;
    logic [47:0] lk_mac;
    logic [7:0] rx_data = '0, tx_data, arp_rx_count;
    logic rx_valid = 1'b0, rx_last = 1'b0;
    logic tx_grant = 1'b0, tx_ready = 1'b1;

    int n_checks = 0, n_fail = 0;
    int done_cnt = 0, err_cnt = 0, frames = 0, cur_len = 0, last_len = 0;
    int viol = 0, stalls = 0, gdly = 0, cyc = 0;
    logic [47:0] done_mac = '0;
    logic [7:0] cap [0:63];
    logic [7:0] last_frame [0:63];
    logic granted = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    logic [7:0] exp_cnt = '0;

    always #5 clk = ~clk;

    arp_resolver #(.RETRIES(RETRIES), .TMR_W(TMR_W)) u_arp_resolver (
        .clk(clk), .rst_n(rst_n), .local_ip(MY_IP), .local_mac(MY_MAC),
        .timeout_cycles(timeout_cycles), .lk_req(lk_req), .lk_ip(lk_ip),
        .lk_done(lk_done), .lk_err(lk_err), .lk_mac(lk_mac),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
        .tx_req(tx_req), .tx_grant(tx_grant), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .arp_rx_count(arp_rx_count));

    // Output monitors (sampling only)
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (lk_done) begin done_cnt <= done_cnt + 1; done_mac <= lk_mac; end
        if (lk_err) err_cnt <= err_cnt + 1;
        if (tx_valid && !granted) viol <= viol + 1;
        if (tx_req && tx_grant) granted <= 1'b1;
        if (tx_valid && !tx_ready) stalls <= stalls + 1;
        if (tx_valid && tx_ready) begin
            cap[cur_len[5:0]] = tx_data;
            if (tx_last) begin
                for (int i = 0; i < 64; i++) last_frame[i] <= cap[i];
                last_len <= cur_len + 1;
                cur_len  <= 0;
                frames   <= frames + 1;
                granted  <= 1'b0;
            end else if (cur_len < 63) begin
                cur_len <= cur_len + 1;
            end
        end
    end

    // Arbiter and sink model: grant after a delay, ready from an LFSR
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready <= lfsr[0] | lfsr[2];
        if (tx_req) gdly <= gdly + 1; else gdly <= 0;
        tx_grant <= tx_req && (gdly >= 3);
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_tx_byte(int i, bit rep, logic [47:0] peer_mac, logic [31:0] tip);
        logic [47:0] dst = rep ? peer_mac : 48'hFFFF_FFFF_FFFF;
        logic [47:0] tha = rep ? peer_mac : 48'h0;
        if (i < 6)  return dst[8*(5-i) +: 8];
        if (i < 12) return MY_MAC[8*(11-i) +: 8];
        case (i)
            12: return 8'h08; 13: return 8'h06; 14: return 8'h00; 15: return 8'h01;
            16: return 8'h08; 17: return 8'h00; 18: return 8'h06; 19: return 8'h04;
            20: return 8'h00; 21: return rep ? 8'h02 : 8'h01;
            default: ;
        endcase
        if (i < 28) return MY_MAC[8*(27-i) +: 8];
        if (i < 32) return MY_IP[8*(31-i) +: 8];
        if (i < 38) return tha[8*(37-i) +: 8];
        return tip[8*(41-i) +: 8];
    endfunction

    function automatic logic [7:0] rx_byte(int i, logic [7:0] op, logic [47:0] sha,
                                           logic [31:0] spa, logic [31:0] tpa);
        if (i < 6)  return 8'hFF;
        if (i < 12) return sha[8*(11-i) +: 8];
        case (i)
            12: return 8'h08; 13: return 8'h06; 14: return 8'h00; 15: return 8'h01;
            16: return 8'h08; 17: return 8'h00; 18: return 8'h06; 19: return 8'h04;
            20: return 8'h00; 21: return op;
            default: ;
        endcase
        if (i < 28) return sha[8*(27-i) +: 8];
        if (i < 32) return spa[8*(31-i) +: 8];
        if (i < 38) return 8'h00;
        if (i < 42) return tpa[8*(41-i) +: 8];
        return 8'h00;
    endfunction

    task automatic send_rx(input logic [7:0] op, input logic [47:0] sha, input logic [31:0] spa,
                           input logic [31:0] tpa, input int len, input int bad_pos, input bit gaps);
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 7 == 3)) begin
                rx_valid = 1'b0; rx_last = 1'b0;
                @(negedge clk);
            end
            rx_data  = rx_byte(i, op, sha, spa, tpa) ^ ((i == bad_pos) ? 8'h10 : 8'h00);
            rx_valid = 1'b1;
            rx_last  = (i == len - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_lookup(input logic [31:0] ip);
        lk_ip = ip; lk_req = 1'b1;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        for (int k = 0; k < 3000 && frames < target; k++) @(negedge clk);
    endtask

    task automatic check_frame(input string tag, input bit rep, input logic [47:0] peer,
                               input logic [31:0] tip);
        int bad = -1;
        check({tag, " frame length"}, 64'(last_len), 64'd42);
        for (int i = 0; i < 42; i++)
            if (bad < 0 && last_frame[i] !== exp_tx_byte(i, rep, peer, tip)) bad = i;
        n_checks++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s: byte %0d actual %0h expected %0h", tag, bad,
                     last_frame[bad], exp_tx_byte(bad, rep, peer, tip));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        int f0, d0, e0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 lk_done", 64'(lk_done), 0);
        check("R9 lk_err", 64'(lk_err), 0);
        check("R9 tx_req", 64'(tx_req), 0);
        check("R9 tx_valid", 64'(tx_valid), 0);
        check("R9 count", 64'(arp_rx_count), 0);

        // R9/R2: first lookup misses and broadcasts a request
        pulse_lookup(IP_A);
        check("R9 empty cache miss", 64'(lk_done), 0);
        wait_frames(1);
        check("R2 one request", 64'(frames), 1);
        check_frame("R2 request", 1'b0, 48'h0, IP_A);
        check("R3 no byte before grant", 64'(viol), 0);

        // R4: matching reply fills the cache (reply: op 2, aimed at us, with gaps)
        send_rx(8'h02, MAC_A, IP_A, MY_IP, 42, -1, 1'b1);
        exp_cnt++;
        check("R4 done count", 64'(done_cnt), 1);
        check("R4 resolved mac", done_mac, 64'(MAC_A));
        check("R7 count reply", 64'(arp_rx_count), 64'(exp_cnt));
        check("R6 no reply to a reply", 64'(frames), 1);

        // R1: hit answers in the next cycle without a frame
        pulse_lookup(IP_A);
        check("R1 hit latency", 64'(lk_done), 1);
        check("R1 hit mac", lk_mac, 64'(MAC_A));
        repeat (100) @(negedge clk);
        check("R1 no frame on hit", 64'(frames), 1);

        // R6: request for our IP gets a reply; request for another IP does not
        send_rx(8'h01, MAC_X, IP_X, MY_IP, 60, -1, 1'b0);
        exp_cnt++;
        wait_frames(2);
        check("R6 reply sent", 64'(frames), 2);
        check_frame("R6 reply", 1'b1, MAC_X, IP_X);
        send_rx(8'h01, MAC_X, IP_X, IP_C, 42, -1, 1'b0);
        exp_cnt++;
        repeat (100) @(negedge clk);
        check("R6 foreign request ignored", 64'(frames), 2);
        check("R7 count requests", 64'(arp_rx_count), 64'(exp_cnt));

        // R5/R8: unanswered lookup with a non-matching answer in between
        timeout_cycles = 16'd150;
        f0 = frames; d0 = done_cnt; e0 = err_cnt;
        pulse_lookup(IP_B);
        repeat (10) @(negedge clk);
        send_rx(8'h02, MAC_C, IP_C, MY_IP, 42, -1, 1'b0);
        exp_cnt++;
        for (int k = 0; k < 3000 && err_cnt == e0; k++) @(negedge clk);
        check("R5 error pulse", 64'(err_cnt - e0), 1);
        check("R5 frame count", 64'(frames - f0), 64'(RETRIES + 1));
        check_frame("R5 retry frame", 1'b0, 48'h0, IP_B);
        check("R8 no done on mismatch", 64'(done_cnt - d0), 0);
        pulse_lookup(IP_A);
        check("R8 cache kept", 64'(lk_done), 1);
        check("R8 cache mac kept", lk_mac, 64'(MAC_A));

        // R7: corrupt each checked header byte; short frame; padded frame
        for (int p = 12; p <= 21; p++) begin
            send_rx(8'h01, MAC_X, IP_X, MY_IP, 42, p, 1'b0);
            check($sformatf("R7 corrupt byte %0d", p), 64'(arp_rx_count), 64'(exp_cnt));
        end
        send_rx(8'h01, MAC_X, IP_X, MY_IP, 41, -1, 1'b0);
        check("R7 short frame", 64'(arp_rx_count), 64'(exp_cnt));
        repeat (100) @(negedge clk);
        check("R7 bad frames not answered", 64'(frames), 64'(f0 + RETRIES + 1));
        send_rx(8'h03, MAC_X, IP_X, MY_IP, 42, -1, 1'b0);
        check("R7 opcode 3 rejected", 64'(arp_rx_count), 64'(exp_cnt));

        // R7: wrap the counter
        while (exp_cnt != 8'd0) begin
            send_rx(8'h02, MAC_C, IP_C, MY_IP, 42, -1, 1'b0);
            exp_cnt++;
        end
        check("R7 counter wrap", 64'(arp_rx_count), 0);
        check("R3 stalls exercised", 64'(stalls > 0), 1);
        check("R3 no byte before grant end", 64'(viol), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule